// File: doc/BRIEF.md
# Programmable Memory Window Address Decoder

This block takes an address issued by a data-moving engine and finds which of eight programmable memory windows contains it. Every window has three registers: a base word, a size word and a high-remap word. The base word also carries the memory target identifier and an attribute byte. Windows are sized and aligned in 64 KB granules. Two requesting ports share the window set. Each port has its own enable word, which switches individual windows on for that port and gives each window a two-bit access-rights code.

Each request gives a port, an address and a read/write flag. One clock later the block returns one of two results. The first is a hit, with the winning window's index, target, attribute, remap word and a permission verdict. The second is a miss, with every result field at zero. The registers are written and read through a simple word-addressed configuration port. Writes take effect at the clock edge.

Top module: `xwin_decoder`

## Requirements
- R1: After reset every register reads zero, and any request misses.
- R2: Configuration word address {group[4:3], index[2:0]} selects the register. Group 0 is the base of window index. Group 1 is the size of window index, and only bits [31:16] are kept (bits [15:0] read zero). Group 2 is the remap word of window index. In group 3, index 0 and 1 are the enable words of port 0 and port 1, and index 2 and 3 are two override words. Group 3 indices 4 to 7 hold nothing and read zero. A written value reads back on cfg_rdata in the following cycle.
- R3: An address hits window i when (addr[31:16] XOR base[31:16]) AND NOT size[31:16] is zero, so the granule is 64 KB.
- R4: A window can hit for a port only when bit i of that port's enable word is set. req_port selects the enable word: 0 selects port 0, 1 selects port 1.
- R5: When several windows hit, the lowest-numbered one is reported.
- R6: On a miss, rsp_hit, rsp_win, rsp_target, rsp_attr, rsp_remap, rsp_allowed and rsp_violation are all zero.
- R7: The rights code for window i sits in bits [17+2i:16+2i] of the port's enable word. Code 3 allows reads and writes. Code 1 allows reads only. Codes 0 and 2 allow nothing. rsp_allowed reports the verdict for the request's direction.
- R8: rsp_violation is set exactly when a write hits a window whose rights code is 1.
- R9: rsp_valid is high in the cycle after a cycle with req_valid high, and low otherwise.
- R10: When a request and a configuration write share a cycle, the request is decoded with the register values from before that write.
- R11: On a hit, rsp_target is base[3:0] and rsp_attr is base[15:8] of the winning window. rsp_remap is that window's remap word and rsp_win is its index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Register value at cfg_addr |
| req_valid | input | 1 | Request present this cycle |
| req_port | input | 1 | Requesting port (0 or 1) |
| req_addr | input | 32 | Address to decode |
| req_write | input | 1 | Request is a write |
| rsp_valid | output | 1 | Result valid |
| rsp_hit | output | 1 | A window matched |
| rsp_win | output | 3 | Index of winning window |
| rsp_target | output | 4 | Target identifier of winning window |
| rsp_attr | output | 8 | Attribute of winning window |
| rsp_remap | output | 32 | Remap word of winning window |
| rsp_allowed | output | 1 | Access permitted |
| rsp_violation | output | 1 | Write to a read-only window |

## Verification
A configuration write and an address decode can occur in the same clock cycle, and the decode must see the register values from before the write. The bench provokes this in two ways. It uses a directed case that disables the only matching window in the very cycle a request to it is issued. It also uses random traffic that mixes writes to enable, base and size registers with requests. The reference model predicts every result from its register copy taken before the cycle's write, and applies the write only after the clock edge. A design that forwarded the new value would show a hit turning into a miss, or a changed window, one cycle early.

// File: rtl/xwin_pkg.sv
package xwin_pkg;

    localparam int REG_W      = 32;
    localparam int NUM_PORTS  = 2;
    localparam int RIGHTS_LSB = 16;

    typedef enum logic [1:0] {
        RIGHT_NONE = 2'd0,
        RIGHT_RO   = 2'd1,
        RIGHT_RSV  = 2'd2,
        RIGHT_RW   = 2'd3
    } rights_e;

    typedef struct packed {
        logic [REG_W-1:0] base;
        logic [REG_W-1:0] size;
        logic [REG_W-1:0] remap;
    } win_regs_t;

endpackage

// File: rtl/xwin_regfile.sv
module xwin_regfile
    import xwin_pkg::*;
#(
    parameter int NUM_WIN  = 8,
    parameter int GRAN_LSB = 16,
    parameter int CFG_AW   = 5
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cfg_we,
    input  logic [CFG_AW-1:0]                   cfg_addr,
    input  logic [REG_W-1:0]                    cfg_wdata,
    output logic [REG_W-1:0]                    cfg_rdata,
    output win_regs_t [NUM_WIN-1:0]             win_o,
    output logic [NUM_PORTS-1:0][REG_W-1:0]     en_o
);

    localparam int IDX_W = CFG_AW - 2;
    localparam logic [REG_W-1:0] SIZE_KEEP = ~((REG_W'(1) << GRAN_LSB) - REG_W'(1));

    typedef struct packed {
        win_regs_t [NUM_WIN-1:0]             win;
        logic [NUM_PORTS-1:0][REG_W-1:0]     en;
        logic [NUM_PORTS-1:0][REG_W-1:0]     ovr;
    } cfg_t;

    cfg_t st_d, st_q;

    logic [1:0]       grp;
    logic [IDX_W-1:0] idx;

    assign grp = cfg_addr[CFG_AW-1 -: 2];
    assign idx = cfg_addr[IDX_W-1:0];

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            case (grp)
                2'd0: begin
                    for (int i = 0; i < NUM_WIN; i++)
                        if (int'(idx) == i) st_d.win[i].base = cfg_wdata;
                end
                2'd1: begin
                    for (int i = 0; i < NUM_WIN; i++)
                        if (int'(idx) == i) st_d.win[i].size = cfg_wdata & SIZE_KEEP;
                end
                2'd2: begin
                    for (int i = 0; i < NUM_WIN; i++)
                        if (int'(idx) == i) st_d.win[i].remap = cfg_wdata;
                end
                default: begin
                    for (int p = 0; p < NUM_PORTS; p++) begin
                        if (int'(idx) == p)             st_d.en[p]  = cfg_wdata;
                        if (int'(idx) == p + NUM_PORTS) st_d.ovr[p] = cfg_wdata;
                    end
                end
            endcase
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (grp)
            2'd0: begin
                for (int i = 0; i < NUM_WIN; i++)
                    if (int'(idx) == i) cfg_rdata = st_q.win[i].base;
            end
            2'd1: begin
                for (int i = 0; i < NUM_WIN; i++)
                    if (int'(idx) == i) cfg_rdata = st_q.win[i].size;
            end
            2'd2: begin
                for (int i = 0; i < NUM_WIN; i++)
                    if (int'(idx) == i) cfg_rdata = st_q.win[i].remap;
            end
            default: begin
                for (int p = 0; p < NUM_PORTS; p++) begin
                    if (int'(idx) == p)             cfg_rdata = st_q.en[p];
                    if (int'(idx) == p + NUM_PORTS) cfg_rdata = st_q.ovr[p];
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign win_o = st_q.win;
    assign en_o  = st_q.en;

endmodule

// File: rtl/xwin_match.sv
module xwin_match
    import xwin_pkg::*;
#(
    parameter int NUM_WIN  = 8,
    parameter int GRAN_LSB = 16
) (
    input  logic [REG_W-1:0]        addr,
    input  win_regs_t [NUM_WIN-1:0] win,
    input  logic [NUM_WIN-1:0]      win_en,
    output logic [NUM_WIN-1:0]      hit
);

    localparam int HI_W = REG_W - GRAN_LSB;

    logic [HI_W-1:0] addr_hi;
    assign addr_hi = addr[REG_W-1:GRAN_LSB];

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        logic [HI_W-1:0] diff;
        logic [HI_W-1:0] care;
        assign diff   = addr_hi ^ win[i].base[REG_W-1:GRAN_LSB];
        assign care   = ~win[i].size[REG_W-1:GRAN_LSB];
        assign hit[i] = win_en[i] && ((diff & care) == '0);
    end

    logic unused_match;
    assign unused_match = ^addr[GRAN_LSB-1:0];

endmodule

// File: rtl/xwin_prio.sv
module xwin_prio #(
    parameter int NUM_WIN = 8,
    parameter int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic [NUM_WIN-1:0] hit,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);

    always_comb begin
        found = |hit;
        idx   = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--)
            if (hit[i]) idx = IDX_W'(i);
    end

endmodule

// File: rtl/xwin_decoder.sv
module xwin_decoder
    import xwin_pkg::*;
#(
    parameter int NUM_WIN  = 8,
    parameter int GRAN_LSB = 16,
    parameter int TGT_W    = 4,
    parameter int ATTR_LSB = 8,
    parameter int ATTR_W   = 8,
    parameter int IDX_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
    parameter int CFG_AW   = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              req_valid,
    input  logic              req_port,
    input  logic [31:0]       req_addr,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_win,
    output logic [TGT_W-1:0]  rsp_target,
    output logic [ATTR_W-1:0] rsp_attr,
    output logic [31:0]       rsp_remap,
    output logic              rsp_allowed,
    output logic              rsp_violation
);

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [IDX_W-1:0]  win;
        logic [TGT_W-1:0]  tgt;
        logic [ATTR_W-1:0] attr;
        logic [REG_W-1:0]  remap;
        logic              allowed;
        logic              viol;
    } rsp_t;

    win_regs_t [NUM_WIN-1:0]         win;
    logic [NUM_PORTS-1:0][REG_W-1:0] port_en;
    logic [REG_W-1:0]                sel_en;
    logic [NUM_WIN-1:0]              hit_vec;
    logic                            found;
    logic [IDX_W-1:0]                win_idx;
    rights_e                         rights;
    rsp_t                            rsp_d, rsp_q;

    xwin_regfile #(
        .NUM_WIN  (NUM_WIN),
        .GRAN_LSB (GRAN_LSB),
        .CFG_AW   (CFG_AW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .win_o     (win),
        .en_o      (port_en)
    );

    assign sel_en = port_en[req_port];

    xwin_match #(
        .NUM_WIN  (NUM_WIN),
        .GRAN_LSB (GRAN_LSB)
    ) u_match (
        .addr   (req_addr),
        .win    (win),
        .win_en (sel_en[NUM_WIN-1:0]),
        .hit    (hit_vec)
    );

    xwin_prio #(
        .NUM_WIN (NUM_WIN),
        .IDX_W   (IDX_W)
    ) u_prio (
        .hit   (hit_vec),
        .found (found),
        .idx   (win_idx)
    );

    always_comb begin
        rsp_d  = '0;
        rights = rights_e'(sel_en[RIGHTS_LSB + 2*int'(win_idx) +: 2]);
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            if (found) begin
                rsp_d.hit     = 1'b1;
                rsp_d.win     = win_idx;
                rsp_d.tgt     = win[win_idx].base[TGT_W-1:0];
                rsp_d.attr    = win[win_idx].base[ATTR_LSB +: ATTR_W];
                rsp_d.remap   = win[win_idx].remap;
                rsp_d.allowed = (rights == RIGHT_RW) ||
                                ((rights == RIGHT_RO) && !req_write);
                rsp_d.viol    = (rights == RIGHT_RO) && req_write;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid     = rsp_q.valid;
    assign rsp_hit       = rsp_q.hit;
    assign rsp_win       = rsp_q.win;
    assign rsp_target    = rsp_q.tgt;
    assign rsp_attr      = rsp_q.attr;
    assign rsp_remap     = rsp_q.remap;
    assign rsp_allowed   = rsp_q.allowed;
    assign rsp_violation = rsp_q.viol;

    logic unused_top;
    assign unused_top = ^{sel_en[RIGHTS_LSB-1:NUM_WIN]};

endmodule

// File: rtl/xwin_decoder_chk.sv
module xwin_decoder_chk #(
    parameter int IDX_W  = 3,
    parameter int TGT_W  = 4,
    parameter int ATTR_W = 8,
    parameter int CFG_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [31:0]       cfg_wdata,
    input logic [31:0]       cfg_rdata,
    input logic              req_valid,
    input logic              req_port,
    input logic [31:0]       req_addr,
    input logic              req_write,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [IDX_W-1:0]  rsp_win,
    input logic [TGT_W-1:0]  rsp_target,
    input logic [ATTR_W-1:0] rsp_attr,
    input logic [31:0]       rsp_remap,
    input logic              rsp_allowed,
    input logic              rsp_violation
);

    assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_rsp_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_miss_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_win == '0 && rsp_target == '0 && rsp_attr == '0
                                     && rsp_remap == '0 && !rsp_allowed && !rsp_violation));

    assert_viol_denied_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_violation |-> (rsp_hit && !rsp_allowed));

    assert_read_no_viol_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> !rsp_violation);

    assert_allowed_needs_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_allowed |-> (rsp_valid && rsp_hit));

endmodule

bind xwin_decoder xwin_decoder_chk #(
    .IDX_W  (IDX_W),
    .TGT_W  (TGT_W),
    .ATTR_W (ATTR_W),
    .CFG_AW (CFG_AW)
) u_chk (.*);

// File: tb/xwin_decoder_test.sv
`timescale 1ns/1ps
module xwin_decoder_test;

    typedef struct packed {
        logic        hit;
        logic [2:0]  win;
        logic [3:0]  tgt;
        logic [7:0]  attr;
        logic [31:0] remap;
        logic        ok;
        logic        viol;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [4:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        req_valid;
    logic        req_port;
    logic [31:0] req_addr;
    logic        req_write;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [2:0]  rsp_win;
    logic [3:0]  rsp_target;
    logic [7:0]  rsp_attr;
    logic [31:0] rsp_remap;
    logic        rsp_allowed;
    logic        rsp_violation;

    int nvec = 0;
    int nerr = 0;

    logic [31:0] m_base  [8];
    logic [31:0] m_size  [8];
    logic [31:0] m_remap [8];
    logic [31:0] m_en    [2];
    logic [31:0] m_ovr   [2];

    always #2 clk = ~clk;

    xwin_decoder uut (.*);

    function automatic exp_t model(input bit port, input logic [31:0] a, input bit wr);
        exp_t e = '0;
        for (int i = 7; i >= 0; i--) begin
            if (m_en[port][i] &&
                (((a[31:16] ^ m_base[i][31:16]) & ~m_size[i][31:16]) == 16'h0)) begin
                logic [1:0] r;
                r       = m_en[port][16 + 2*i +: 2];
                e.hit   = 1'b1;
                e.win   = 3'(i);
                e.tgt   = m_base[i][3:0];
                e.attr  = m_base[i][15:8];
                e.remap = m_remap[i];
                e.ok    = (r == 2'd3) || (r == 2'd1 && !wr);
                e.viol  = (r == 2'd1) && wr;
            end
        end
        return e;
    endfunction

    function automatic logic [31:0] mdl_read(input logic [4:0] a);
        case (a[4:3])
            2'd0: return m_base[a[2:0]];
            2'd1: return m_size[a[2:0]];
            2'd2: return m_remap[a[2:0]];
            default: case (a[2:0])
                3'd0: return m_en[0];
                3'd1: return m_en[1];
                3'd2: return m_ovr[0];
                3'd3: return m_ovr[1];
                default: return 32'h0;
            endcase
        endcase
    endfunction

    task automatic mdl_write(input logic [4:0] a, input logic [31:0] d);
        case (a[4:3])
            2'd0: m_base[a[2:0]]  = d;
            2'd1: m_size[a[2:0]]  = d & 32'hFFFF_0000;
            2'd2: m_remap[a[2:0]] = d;
            default: case (a[2:0])
                3'd0: m_en[0]  = d;
                3'd1: m_en[1]  = d;
                3'd2: m_ovr[0] = d;
                3'd3: m_ovr[1] = d;
                default: ;
            endcase
        endcase
    endtask

    task automatic cyc(input bit we, input logic [4:0] ca, input logic [31:0] cd,
                       input bit rv, input bit port, input logic [31:0] ra,
                       input bit rw, input string tag);
        exp_t e, act;
        e = model(port, ra, rw);
        cfg_we = we; cfg_addr = ca; cfg_wdata = cd;
        req_valid = rv; req_port = port; req_addr = ra; req_write = rw;
        @(posedge clk);
        if (we) mdl_write(ca, cd);
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        act = {rsp_hit, rsp_win, rsp_target, rsp_attr, rsp_remap, rsp_allowed, rsp_violation};
        nvec++;
        if (rsp_valid !== rv || (rv && act !== e)) begin
            nerr++;
            $display("FAIL %s: actual valid=%0b fields=%h expected valid=%0b fields=%h",
                     tag, rsp_valid, act, rv, e);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input string tag);
        cyc(1'b1, a, d, 1'b0, 1'b0, 32'h0, 1'b0, tag);
    endtask

    task automatic rq(input bit port, input logic [31:0] a, input bit w, input string tag);
        cyc(1'b0, 5'd0, 32'h0, 1'b1, port, a, w, tag);
    endtask

    task automatic rd(input logic [4:0] a, input string tag);
        cfg_addr = a;
        #0.5;
        nvec++;
        if (cfg_rdata !== mdl_read(a)) begin
            nerr++;
            $display("FAIL %s: reg %0d actual=%h expected=%h", tag, a, cfg_rdata, mdl_read(a));
        end
    endtask

    function automatic logic [31:0] rnd_data(input logic [4:0] a);
        logic [31:0] r, s;
        r = $urandom;
        s = $urandom;
        case (a[4:3])
            2'd0: return {16'h4000 + 16'((s % 8) * 4), r[15:0]};
            2'd1: return ((32'h1 << (s % 6)) - 32'h1) << 16 | {16'h0, r[15:0]};
            default: return r;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) begin
            m_base[i] = '0; m_size[i] = '0; m_remap[i] = '0;
        end
        m_en[0] = '0; m_en[1] = '0; m_ovr[0] = '0; m_ovr[1] = '0;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        req_valid = 1'b0; req_port = 1'b0; req_addr = '0; req_write = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 32; a++) rd(5'(a), "R1 reset readback");
        rq(1'b0, 32'h0000_0000, 1'b0, "R1 R6 miss after reset");
        rq(1'b1, 32'hFFFF_FFFF, 1'b1, "R1 R6 miss after reset port1");

        // R2: programming and readback
        wr(5'd0,  32'h1230_AB05, "R2 base0");
        wr(5'd8,  32'h000F_FFFF, "R2 size0");
        wr(5'd16, 32'hDEAD_0000, "R2 remap0");
        wr(5'd24, 32'h0003_0001, "R2 en0");
        wr(5'd26, 32'h5A5A_1234, "R2 ovr0");
        wr(5'd30, 32'hFFFF_FFFF, "R2 empty slot");
        for (int a = 0; a < 32; a++) rd(5'(a), "R2 readback");

        // R3 R11: granule matching and result fields
        rq(1'b0, 32'h1230_0000, 1'b0, "R3 R11 first granule");
        rq(1'b0, 32'h123F_FFFF, 1'b1, "R3 last byte");
        rq(1'b0, 32'h1240_0000, 1'b0, "R3 R6 just above");
        rq(1'b0, 32'h122F_FFFF, 1'b0, "R3 R6 just below");

        // R4: per-port enables
        rq(1'b1, 32'h1230_0000, 1'b0, "R4 port1 disabled");
        wr(5'd25, 32'h0003_0001, "R4 en1");
        rq(1'b1, 32'h1234_5678, 1'b1, "R4 port1 enabled");

        // R5: priority
        wr(5'd3,  32'h1200_7704, "R5 base3");
        wr(5'd11, 32'h00FF_0000, "R5 size3");
        wr(5'd19, 32'hBEEF_0000, "R5 remap3");
        wr(5'd24, 32'h00C3_0009, "R5 en0");
        rq(1'b0, 32'h1230_1000, 1'b0, "R5 lowest wins");
        rq(1'b0, 32'h1250_0000, 1'b0, "R5 R11 only window3");
        wr(5'd24, 32'h00C0_0008, "R5 en0 drop w0");
        rq(1'b0, 32'h1230_1000, 1'b0, "R5 window3 after drop");

        // R7 R8: rights codes
        wr(5'd24, 32'h0040_0008, "R7 ro");
        rq(1'b0, 32'h1250_0000, 1'b0, "R7 ro read");
        rq(1'b0, 32'h1250_0000, 1'b1, "R8 ro write");
        wr(5'd24, 32'h0000_0008, "R7 none");
        rq(1'b0, 32'h1250_0000, 1'b0, "R7 none read");
        rq(1'b0, 32'h1250_0000, 1'b1, "R7 R8 none write");
        wr(5'd24, 32'h0080_0008, "R7 rsv");
        rq(1'b0, 32'h1250_0000, 1'b1, "R7 rsv write");
        wr(5'd24, 32'h00C0_0008, "R7 rw");
        rq(1'b0, 32'h1250_0000, 1'b1, "R7 rw write");

        // R10: write and request in the same cycle
        cyc(1'b1, 5'd24, 32'h0, 1'b1, 1'b0, 32'h1250_0000, 1'b0, "R10 old values used");
        rq(1'b0, 32'h1250_0000, 1'b0, "R10 new values after");

        // R9: idle cycles give no result
        for (int k = 0; k < 3; k++) cyc(1'b0, 5'd0, 32'h0, 1'b0, 1'b0, 32'h1250_0000, 1'b0, "R9 idle");

        // random configuration
        for (int w = 0; w < 8; w++) begin
            wr(5'(w),      rnd_data(5'(w)),      "R2 rand base");
            wr(5'(8 + w),  rnd_data(5'(8 + w)),  "R2 rand size");
            wr(5'(16 + w), rnd_data(5'(16 + w)), "R2 rand remap");
        end
        wr(5'd24, $urandom, "R4 rand en0");
        wr(5'd25, $urandom, "R4 rand en1");

        // random mixed traffic: R3 R4 R5 R7 R8 R9 R10 R11
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] r1, r2, r3, ra;
            logic [4:0]  ca;
            bit          we, rv;
            r1 = $urandom; r2 = $urandom; r3 = $urandom;
            we = (r1 % 10) == 0;
            rv = (r1[15:8] % 10) < 7;
            ca = r2[4:0];
            if (ca[4:3] == 2'd3) ca[2] = 1'b0;
            ra = {16'h4000 + 16'(r3[31:16] % 40), r3[15:0]};
            cyc(we, ca, rnd_data(ca), rv, r2[8], ra, r2[9], "R3 R5 R7 R10 random");
            if ((k % 100) == 0) rd(ca, "R2 random readback");
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule